// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Source

This block stands in for a serial configuration memory that feeds a stored bitstream, one bit per configuration clock, into a programmable logic device. The receiver controls it through three inputs: a configuration clock, an active-low select, and an output enable. Pulling the output enable low also clears the read position. The block drives a serial data line that it can release, and an active-low cascade output. A fixed bit pattern set by a parameter is the stored content, and a parameter sets its length.

A device at the head of a chain first sends a run of forced-high synchronisation bits and then its stored bits, least significant bit first. After its last bit it releases its data line and pulls its cascade output low. That cascade output drives the select of the next device in the chain, which continues the stream with no gap. Later devices are built without the synchronisation run, so the whole chain delivers one continuous stream.

Top module: `cfgsrc_stream`

## Requirements
- R1: An active reset, or output enable low at any time (asynchronously, even between clock edges), returns the read position to the start of the stream.
- R2: `data_oe_o` is high only while output enable is high, select is low and the stream is not finished; whenever `data_oe_o` is low, `data_o` reads 0.
- R3: With `HAS_SYNC=1`, the first `SYNC_BITS` (default 8) bits presented after the start of the stream are all 1.
- R4: Stream position `LEAD+k` carries `ROM_INIT[k]` (bit 0 first), where `LEAD` is `SYNC_BITS` or 0. With the default settings the first stored bit is the one the receiver samples on the ninth rising edge.
- R5: The presented bit changes only on a rising clock edge, and each enabled edge advances the stream by exactly one bit.
- R6: On the rising edge that follows the presentation of the last stored bit, `cascade_no` falls and `data_oe_o` falls. The cascade output and the data enable are never active together.
- R7: While select is high, `cascade_no` is high.
- R8: Rising edges while select is high or output enable is low do not advance the position. After select returns low, the stream resumes at the bit it had reached.
- R9: Once finished, the block stays finished through any further edges until R1 clears it.
- R10: With `HAS_SYNC=0` there is no synchronisation run. Two devices chained through cascade-to-select deliver the synchronisation run, then the first ROM, then the second ROM, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low select |
| oe_i | input | 1 | Output enable; low clears the read position |
| data_o | output | 1 | Serial data bit, 0 when not driven |
| data_oe_o | output | 1 | Drive enable for the serial data line |
| cascade_no | output | 1 | Active-low select for the next device in the chain |

## Verification
The step and hold assertions assume that output enable changes only away from the clock edges, and that select stays settled across each rising edge. The cascade assertion also assumes that select is not toggled while the stream is already finished. The stimulus changes its inputs 2 ns after each rising edge. It pulses output enable low between edges only to clear the position, and each time it reselects a finished device it first clears the position. In this way all the inputs stay inside those assumptions.

// File: rtl/cfgsrc_pkg.sv
package cfgsrc_pkg;
  function automatic int lead_bits(bit has_sync, int sync_bits);
    return has_sync ? sync_bits : 0;
  endfunction

  function automatic int idx_width(int total);
    return $clog2(total + 1);
  endfunction
endpackage

// File: rtl/cfgsrc_bitcnt.sv
module cfgsrc_bitcnt #(
  parameter int TOTAL = 40,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             oe_i,
  input  logic             cs_ni,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic [IDX_W-1:0] idx_q;

  assign done_o = (idx_q == IDX_W'(TOTAL));
  assign idx_o  = idx_q;

  // oe_i low clears the position asynchronously
  always_ff @(posedge clk_i or negedge rst_ni or negedge oe_i) begin
    if (!rst_ni)                idx_q <= '0;
    else if (!oe_i)             idx_q <= '0;
    else if (!cs_ni && !done_o) idx_q <= idx_q + 1'b1;
  end

  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni || !oe_i)
    (!cs_ni && !done_o) |=> (idx_q == $past(idx_q) + 1'b1) || (idx_q == '0)); // R5
  AST_HOLD_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni || !oe_i)
    cs_ni |=> $stable(idx_q) || (idx_q == '0)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni || !oe_i)
    done_o |=> done_o || (idx_q == '0)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(TOTAL)); // R9
endmodule

// File: rtl/cfgsrc_bitsel.sv
module cfgsrc_bitsel #(
  parameter int                  ROM_BITS = 32,
  parameter logic [ROM_BITS-1:0] ROM_INIT = '0,
  parameter int                  LEAD     = 8,
  parameter int                  IDX_W    = 6
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  logic [IDX_W-1:0] off;

  if (LEAD > 0) begin : g_sync
    assign off = idx_i - IDX_W'(LEAD);
    always_comb begin
      bit_o = 1'b0;
      if (idx_i < IDX_W'(LEAD)) bit_o = 1'b1;
      else begin
        for (int i = 0; i < ROM_BITS; i++)
          if (off == IDX_W'(i)) bit_o = ROM_INIT[i];
      end
    end
  end else begin : g_nosync
    assign off = idx_i;
    always_comb begin
      bit_o = 1'b0;
      for (int i = 0; i < ROM_BITS; i++)
        if (off == IDX_W'(i)) bit_o = ROM_INIT[i];
    end
  end
endmodule

// File: rtl/cfgsrc_drv.sv
module cfgsrc_drv (
  input  logic oe_i,
  input  logic cs_ni,
  input  logic done_i,
  input  logic bit_i,
  output logic data_o,
  output logic data_oe_o,
  output logic cascade_no
);
  logic sel;

  assign sel        = oe_i & ~cs_ni;
  assign data_oe_o  = sel & ~done_i;
  assign data_o     = data_oe_o & bit_i;
  assign cascade_no = ~(~cs_ni & done_i);
endmodule

// File: rtl/cfgsrc_stream.sv
module cfgsrc_stream #(
  parameter int                  ROM_BITS  = 32,
  parameter logic [ROM_BITS-1:0] ROM_INIT  = 32'hA5C3_0F96,
  parameter bit                  HAS_SYNC  = 1'b1,
  parameter int                  SYNC_BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic oe_i,
  output logic data_o,
  output logic data_oe_o,
  output logic cascade_no
);
  import cfgsrc_pkg::*;

  localparam int LEAD  = lead_bits(HAS_SYNC, SYNC_BITS);
  localparam int TOTAL = LEAD + ROM_BITS;
  localparam int IDX_W = idx_width(TOTAL);

  logic [IDX_W-1:0] idx;
  logic             done;
  logic             cur_bit;

  cfgsrc_bitcnt #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .oe_i  (oe_i),
    .cs_ni (cs_ni),
    .idx_o (idx),
    .done_o(done)
  );

  cfgsrc_bitsel #(.ROM_BITS(ROM_BITS), .ROM_INIT(ROM_INIT), .LEAD(LEAD), .IDX_W(IDX_W)) u_sel (
    .idx_i(idx),
    .bit_o(cur_bit)
  );

  cfgsrc_drv u_drv (
    .oe_i      (oe_i),
    .cs_ni     (cs_ni),
    .done_i    (done),
    .bit_i     (cur_bit),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .cascade_no(cascade_no)
  );

  AST_CASC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_oe_o && !cascade_no)); // R6
  AST_CASC_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cascade_no) && $past(!cs_ni) && $past(oe_i)) |-> $past(data_oe_o)); // R6

  if (LEAD > 0) begin : g_sync_chk
    AST_SYNC_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (data_oe_o && (idx < IDX_W'(LEAD))) |-> data_o); // R3
  end
endmodule

// File: tb/tb_cfgsrc_stream.sv
module tb_cfgsrc_stream;
  localparam int B0 = 32;
  localparam int B1 = 16;
  localparam logic [B0-1:0] ROM0 = 32'hA5C3_0F96;
  localparam logic [B1-1:0] ROM1 = 16'h3CE1;
  localparam int TOT0 = 8 + B0;
  localparam int TOT  = TOT0 + B1;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, oe = 1'b0;
  logic d0, d0_oe, c0, d1, d1_oe, c1;
  int checks = 0, fails = 0, pos = 0;
  bit finished = 1'b0;
  string focus = "R1 reset";
  int exp_bits [TOT];

  always #5 clk = ~clk;

  cfgsrc_stream #(.ROM_BITS(B0), .ROM_INIT(ROM0), .HAS_SYNC(1'b1), .SYNC_BITS(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .oe_i(oe),
    .data_o(d0), .data_oe_o(d0_oe), .cascade_no(c0));

  cfgsrc_stream #(.ROM_BITS(B1), .ROM_INIT(ROM1), .HAS_SYNC(1'b0), .SYNC_BITS(8)) dut_nxt (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(c0), .oe_i(oe),
    .data_o(d1), .data_oe_o(d1_oe), .cascade_no(c1));

  initial begin
    for (int i = 0; i < 8; i++)  exp_bits[i] = 1;
    for (int i = 0; i < B0; i++) exp_bits[8 + i] = int'(ROM0[i]);
    for (int i = 0; i < B1; i++) exp_bits[TOT0 + i] = int'(ROM1[i]);
  end

  // reference position of the whole chain
  always @(posedge clk or negedge rst_n or negedge oe) begin
    if (!rst_n || !oe) pos <= 0;
    else if (!cs_n && pos < TOT) pos <= pos + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s [%s] pos=%0d act=%0d exp=%0d", req, what, focus, pos, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(negedge clk) begin
    bit e0_oe, e1_oe, e_c0, e_c1;
    int e_d0, e_d1;
    logic snap;
    e0_oe = oe && !cs_n && pos < TOT0;
    e1_oe = oe && !cs_n && pos >= TOT0 && pos < TOT;
    e_c0  = !(!cs_n && oe && pos >= TOT0);
    e_c1  = !(!cs_n && oe && pos == TOT);
    e_d0  = e0_oe ? exp_bits[pos] : 0;
    e_d1  = e1_oe ? exp_bits[pos] : 0;
    chk(d0_oe == e0_oe, "R2", "dut drive enable", int'(d0_oe), int'(e0_oe));
    chk(int'(d0) == e_d0, (pos < 8) ? "R3" : "R4", "dut data", int'(d0), e_d0);
    chk(c0 == e_c0, cs_n ? "R7" : "R6", "dut cascade", int'(c0), int'(e_c0));
    chk(d1_oe == e1_oe, "R10", "next drive enable", int'(d1_oe), int'(e1_oe));
    chk(int'(d1) == e_d1, "R10", "next data", int'(d1), e_d1);
    chk(c1 == e_c1, "R6", "next cascade", int'(c1), int'(e_c1));
    snap = d0;
    #4;
    chk(d0 == snap, "R5", "dut data stable before edge", int'(d0), int'(snap));
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    focus = "R8 idle"; oe = 1'b1;       edges(3);
    focus = "R3 sync"; cs_n = 1'b0;     edges(8);
    focus = "R4 data";                  edges(10);
    focus = "R8 hold"; cs_n = 1'b1;     edges(4);
    cs_n = 1'b0;
    focus = "R6 handoff";               edges(40);
    focus = "R9 done hold";             edges(6);
    focus = "R7 release"; cs_n = 1'b1;  edges(3);
    focus = "R1 async clear";
    oe = 1'b0; #1; oe = 1'b1;           edges(2);
    focus = "R10 chain"; cs_n = 1'b0;   edges(12);
    focus = "R2 oe low"; oe = 1'b0;     edges(3);
    oe = 1'b1;
    focus = "R10 chain";                edges(60);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #200us;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      summary();
      $finish;
    end
  end
endmodule